// File: doc/BRIEF.md
# Flash Program/Erase Completion Detector

This block tells a flash controller when a parallel NOR device has finished an internal program or erase operation. After the controller has sent the command that started the operation, it pulses `start`. The block then reads the same address over and over through a request/response read port. Each returned status byte is reduced to a single bit and used to decide whether the device is finished.

Two detection modes are available. In toggle mode, bit 6 of the status flips on every read while the device is busy. The block takes one reference read, then compares each new read with the one before it, and finishes when two consecutive reads agree. In polling mode, bit 7 of each read is compared with bit 7 of the byte that was programmed, and the block finishes on the first match.

Every comparing read is counted against a budget set by a parameter. If the budget runs out, the block finishes anyway and flags a timeout, so a stuck device cannot hang the controller.

The read request follows valid/ready rules. Once `rd_req_valid` is raised, it stays high and `rd_addr` stays unchanged until the cycle in which `rd_req_ready` is high. After that handshake no new request is raised until one `rd_rsp_valid` pulse has delivered the data. The response side has no ready signal, because the block always accepts the response it is waiting for.

Top module: `flash_ready_detector`

## Requirements
- R1: After reset, `busy`, `done`, `timeout` and `rd_req_valid` are all low.
- R2: A `start` accepted while idle raises `busy`, and in the next cycle raises `rd_req_valid` with `rd_addr` equal to `target_addr`. While `rd_req_ready` is low, the request stays valid with the same address.
- R3: At most one read is outstanding. After the request handshake, `rd_req_valid` stays low until the response arrives.
- R4: In toggle mode (`poll_mode`=0), the first read is only a reference. Completion is declared on the first read whose bit 6 equals bit 6 of the read just before it. All other bits are ignored.
- R5: In toggle mode, after a read whose bit 6 differs from the reference, that read becomes the new reference.
- R6: In polling mode (`poll_mode`=1), completion is declared on the first read whose bit 7 equals bit 7 of `expect_data` as captured at start. All other bits are ignored.
- R7: At most MAX_ITER comparing reads are made; the toggle reference read does not count. If the MAX_ITER-th comparing read does not match, `done` rises together with `timeout`=1. If it does match, `timeout` stays 0.
- R8: `done` is high for exactly one cycle, the cycle after the final response, and `busy` is already low in that cycle.
- R9: `start` pulses while busy are ignored. The address and mode of the running operation are kept.
- R10: `timeout` holds its value after `done` until the next accepted `start`, which clears it.
- R11: An `rd_rsp_valid` pulse while no read is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin detection (accepted only while idle) |
| poll_mode | input | 1 | 0 = toggle mode, 1 = data-polling mode, captured at start |
| target_addr | input | ADDR_W | Address to read repeatedly, captured at start |
| expect_data | input | DATA_W | Data that was programmed, captured at start |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted by the bus |
| rd_addr | output | ADDR_W | Read address |
| rd_rsp_valid | input | 1 | One-cycle pulse carrying read data |
| rd_rsp_data | input | DATA_W | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Budget exhausted without completion |

## Verification
A `start` seen at one edge shows up as `busy` and `rd_req_valid` in the next cycle. A request handshake at an edge drops `rd_req_valid` in the following cycle. The final response, sampled at an edge, makes `done` and `timeout` visible directly after that edge, and `done` is gone one cycle later. The bench changes inputs on the falling edge and samples outputs on the falling edge that follows each such rising edge. Every check therefore looks at the exact cycle in which its result is due, and the number of reads served before `done` is compared with the expected count.

// File: rtl/frd_pkg.sv
package frd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } frd_state_e;

  typedef enum logic {
    MODE_TOGGLE = 1'b0,
    MODE_POLL   = 1'b1
  } frd_mode_e;
endpackage

// File: rtl/frd_launch.sv
module frd_launch #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              poll_mode,
  input  logic [ADDR_W-1:0] target_addr,
  input  logic [DATA_W-1:0] expect_data,
  output frd_pkg::frd_mode_e mode_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] expect_q
);
  import frd_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_TOGGLE;
      addr_q   <= '0;
      expect_q <= '0;
    end else if (accept) begin
      mode_q   <= poll_mode ? MODE_POLL : MODE_TOGGLE;
      addr_q   <= target_addr;
      expect_q <= expect_data;
    end
  end
endmodule

// File: rtl/frd_sampler.sv
module frd_sampler #(
  parameter int DATA_W     = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int POLL_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  frd_pkg::frd_mode_e mode,
  input  logic [DATA_W-1:0] expect_q,
  input  logic              rsp_fire,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              cmp_read,
  output logic              hit
);
  import frd_pkg::*;

  localparam logic [DATA_W-1:0] TOGGLE_MASK = DATA_W'(1) << TOGGLE_BIT;
  localparam logic [DATA_W-1:0] POLL_MASK   = DATA_W'(1) << POLL_BIT;

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] masked_rd;
  logic [DATA_W-1:0] ref_q;
  logic              have_ref_q;

  always_comb begin
    mask      = (mode == MODE_POLL) ? POLL_MASK : TOGGLE_MASK;
    masked_rd = rsp_data & mask;
    cmp_read  = rsp_fire && ((mode == MODE_POLL) || have_ref_q);
    if (mode == MODE_POLL) hit = (masked_rd == (expect_q & mask));
    else                   hit = (masked_rd == ref_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q      <= '0;
      have_ref_q <= 1'b0;
    end else if (clear) begin
      ref_q      <= '0;
      have_ref_q <= 1'b0;
    end else if (rsp_fire && mode == MODE_TOGGLE) begin
      ref_q      <= masked_rd;
      have_ref_q <= 1'b1;
    end
  end

  // R4: the read that follows a toggle-mode response is always a comparing read
  a_r4_ref_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && !clear && mode == MODE_TOGGLE) |=> have_ref_q);
endmodule

// File: rtl/frd_budget.sv
module frd_budget #(
  parameter int MAX_ITER = 32'h0FFF_FFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last
);
  localparam int CNT_W = $clog2(MAX_ITER + 1);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_ITER - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last = (cnt_q == LAST_VAL);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear)            cnt_q <= '0;
    else if (step && !last)    cnt_q <= cnt_q + 1'b1;
  end

  // R7: the miss counter never passes the budget
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_VAL);
endmodule

// File: rtl/flash_ready_detector.sv
module flash_ready_detector #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int POLL_BIT   = 7,
  parameter int MAX_ITER   = 32'h0FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              poll_mode,
  input  logic [ADDR_W-1:0] target_addr,
  input  logic [DATA_W-1:0] expect_data,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              timeout
);
  import frd_pkg::*;

  frd_state_e state_q, state_d;
  frd_mode_e  mode_q;
  logic [DATA_W-1:0] expect_q;
  logic accept, rsp_fire, cmp_read, hit, last, finish;
  logic done_q, timeout_q;

  assign accept   = start && (state_q == ST_IDLE);
  assign rsp_fire = rd_rsp_valid && (state_q == ST_WAIT);
  assign finish   = cmp_read && (hit || last);

  frd_launch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_launch (
    .clk(clk), .rst_n(rst_n), .accept(accept), .poll_mode(poll_mode),
    .target_addr(target_addr), .expect_data(expect_data),
    .mode_q(mode_q), .addr_q(rd_addr), .expect_q(expect_q)
  );

  frd_sampler #(.DATA_W(DATA_W), .TOGGLE_BIT(TOGGLE_BIT), .POLL_BIT(POLL_BIT)) u_sampler (
    .clk(clk), .rst_n(rst_n), .clear(accept), .mode(mode_q), .expect_q(expect_q),
    .rsp_fire(rsp_fire), .rsp_data(rd_rsp_data), .cmp_read(cmp_read), .hit(hit)
  );

  frd_budget #(.MAX_ITER(MAX_ITER)) u_budget (
    .clk(clk), .rst_n(rst_n), .clear(accept), .step(cmp_read && !hit), .last(last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept)       state_d = ST_ISSUE;
      ST_ISSUE: if (rd_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (rsp_fire)     state_d = finish ? ST_IDLE : ST_ISSUE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      done_q    <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= rsp_fire && finish;
      if (accept)                        timeout_q <= 1'b0;
      else if (rsp_fire && finish && !hit) timeout_q <= 1'b1;
    end
  end

  assign rd_req_valid = (state_q == ST_ISSUE);
  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign timeout      = timeout_q;

  // R2: a stalled request keeps its valid and address
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));
  // R3: no second request right after a handshake
  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> !rd_req_valid);
  // R8: done is a single-cycle pulse, seen while idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7: timeout only ever appears together with done
  a_r7_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);
  // R9: start while busy leaves the address alone
  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(rd_addr));
  // R10: timeout is cleared only by a new accepted start
  a_r10_timeout_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout) |-> busy);
endmodule

// File: tb/flash_ready_detector_tb.sv
module flash_ready_detector_tb;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;
  localparam int MAX_ITER = 4;

  typedef struct packed {
    logic        pm;
    logic [7:0]  expd;
    logic [47:0] seq;   // first read in the top byte
    logic [3:0]  nrd;
    logic        to;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h00, 48'h7F_A5_25_00_00_00, 4'd3, 1'b0}, // R4 R5 noise bits ignored
    '{1'b0, 8'h00, 48'h40_40_00_00_00_00, 4'd2, 1'b0}, // R4 immediate match
    '{1'b0, 8'h00, 48'h40_00_40_00_40_00, 4'd5, 1'b1}, // R7 toggle timeout
    '{1'b0, 8'h00, 48'h00_40_00_00_00_00, 4'd4, 1'b0}, // R5 reference moves
    '{1'b1, 8'h80, 48'h00_7F_80_00_00_00, 4'd3, 1'b0}, // R6
    '{1'b1, 8'h7F, 48'h80_7F_00_00_00_00, 4'd2, 1'b0}, // R6 match on 0
    '{1'b1, 8'h80, 48'h00_00_00_00_00_00, 4'd4, 1'b1}, // R7 poll timeout
    '{1'b1, 8'hFF, 48'h80_00_00_00_00_00, 4'd1, 1'b0}, // R6 first read
    '{1'b1, 8'h80, 48'h00_00_00_80_00_00, 4'd4, 1'b0}, // R7 match on last read
    '{1'b0, 8'h00, 48'h40_00_40_00_00_00, 4'd5, 1'b0}  // R7 toggle match on last
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic poll_mode = 1'b0;
  logic [ADDR_W-1:0] target_addr = '0;
  logic [DATA_W-1:0] expect_data = '0;
  logic rd_req_valid, rd_req_ready = 1'b0;
  logic [ADDR_W-1:0] rd_addr;
  logic rd_rsp_valid = 1'b0;
  logic [DATA_W-1:0] rd_rsp_data = '0;
  logic busy, done, timeout;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flash_ready_detector #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_ITER(MAX_ITER)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_mode(poll_mode),
    .target_addr(target_addr), .expect_data(expect_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .busy(busy), .done(done), .timeout(timeout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic serve_read(input logic [7:0] d, input int stall, input logic [ADDR_W-1:0] a);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(rd_req_valid && rd_addr == a, "R2 stalled request held", int'(rd_addr), int'(a));
    end
    rd_req_ready = 1'b1;
    @(negedge clk);
    rd_req_ready = 1'b0;
    chk(!rd_req_valid, "R3 no request while outstanding", int'(rd_req_valid), 0);
    rd_rsp_valid = 1'b1;
    rd_rsp_data  = d;
    @(negedge clk);
    rd_rsp_valid = 1'b0;
    rd_rsp_data  = '0;
  endtask

  task automatic run_op(input int idx, input vec_t v, input logic [ADDR_W-1:0] a);
    int served = 0;
    string req = v.pm ? "R6/R7" : "R4/R5/R7";
    @(negedge clk);
    poll_mode = v.pm; expect_data = v.expd; target_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0; expect_data = ~v.expd;
    chk(busy, "R2 busy after start", int'(busy), 1);
    chk(!timeout, "R10 timeout cleared by start", int'(timeout), 0);
    for (int k = 0; k < 6; k++) begin
      if (done) break;
      chk(rd_req_valid && rd_addr == a, "R2 request address", int'(rd_addr), int'(a));
      serve_read(v.seq[47-8*k -: 8], k % 3, a);
      served++;
    end
    chk(done, "R8 done after final response", int'(done), 1);
    chk(!busy, "R8 idle with done", int'(busy), 0);
    chk(served == int'(v.nrd), $sformatf("%s vector %0d read count", req, idx), served, int'(v.nrd));
    chk(timeout == v.to, $sformatf("R7 vector %0d timeout flag", idx), int'(timeout), int'(v.to));
    @(negedge clk);
    chk(!done, "R8 done lasts one cycle", int'(done), 0);
    chk(timeout == v.to, "R10 timeout held after done", int'(timeout), int'(v.to));
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !timeout && !rd_req_valid, "R1 reset outputs", int'({busy, done, timeout, rd_req_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_req_valid, "R1 idle after reset", int'({busy, rd_req_valid}), 0);

    for (int i = 0; i < NVEC; i++) begin
      run_op(i, VECS[i], ADDR_W'(24'h1000 + 24'(i) * 24'h111));
      if (i == 2) begin
        repeat (5) @(negedge clk);
        chk(timeout, "R10 timeout holds while idle", int'(timeout), 1);
      end
    end

    // R11 stray response while idle
    rd_rsp_valid = 1'b1; rd_rsp_data = 8'h40;
    @(negedge clk);
    rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    chk(!busy && !done && !rd_req_valid, "R11 idle response ignored", int'({busy, done, rd_req_valid}), 0);

    // R9 start while busy, R11 response while request pending
    poll_mode = 1'b0; target_addr = 24'hABCDE; start = 1'b1;
    @(negedge clk);
    start = 1'b1; target_addr = 24'h12345; poll_mode = 1'b1;
    rd_rsp_valid = 1'b1; rd_rsp_data = 8'h40;
    @(negedge clk);
    start = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    chk(rd_req_valid && rd_addr == 24'hABCDE, "R9 address kept", int'(rd_addr), 24'hABCDE);
    chk(!done, "R11 pending-request response ignored", int'(done), 0);
    serve_read(8'h00, 0, 24'hABCDE);
    chk(!done && rd_req_valid, "R9 toggle mode kept (reference read)", int'(done), 0);
    serve_read(8'h00, 0, 24'hABCDE);
    chk(done && !timeout, "R9 R11 completes on second read", int'({done, timeout}), 2);
    @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule